// File: doc/BRIEF.md
# Score-Gated Offset Prefetch Issuer

This block converts a table of scored cache-line offsets into real prefetch requests. Each time an L2 access is presented, it takes the referenced line address, a snapshot of the offset table with one accuracy score per entry, and a prefetch degree. It then emits a sequence of prefetch line addresses on an output valid/ready stream. No per-stream confirmation is needed, because the scores already record how well each offset predicted past accesses.

The positive offsets are handled first and the negative offsets second. Within each direction, the offset with the smaller magnitude is served first. Each qualifying offset walks one to three lines along its own stride, and the score sets how many. Each direction has its own budget, equal to the degree. A direction stops as soon as its budget is spent. A target address that was already issued during the same access is skipped and does not use any budget.

The input side is a valid/ready handshake. `ref_ready` is high only while no sequence is in progress, so a new access waits until the previous sequence has completed. The output side obeys the usual stream rules. Once `pf_valid` is raised, it stays high and `pf_line` stays unchanged until `pf_ready` accepts the request. Back-pressure therefore stalls the sequence and never drops a request.

Top module: `pf_issue`

## Requirements
- R1: After reset, `ref_ready` is 1 and `pf_valid` is 0.
- R2: A table entry whose score is below 256, or whose offset is 0, issues no prefetch.
- R3: An entry with offset O and score at least 256, 512 or 768 may issue 1, 2 or 3 lines, in the order A+O, A+2O, A+3O, where A is the reference line.
- R4: All positive-offset requests of an access come before any negative-offset request of that access.
- R5: Within one direction, entries are served in order of increasing |O|. When two entries have equal |O|, the lower table index goes first. Entry i occupies bits [i*6 +: 6] of `off_tbl` as a two's-complement value, and bits [i*10 +: 10] of `score_tbl` as an unsigned score.
- R6: Each direction issues at most D requests, where D is `degree` clamped to the range 1 to 8: a value of 0 acts as 1 and values above 8 act as 8. A direction whose budget is spent ends at once, and the other direction starts with a fresh budget of D.
- R7: The degree and the table are captured when the reference is accepted. Changing them later has no effect on that access.
- R8: A target that equals an address already issued during the same access is skipped and consumes no budget.
- R9: While a sequence is in progress, `ref_ready` stays 0, and `pf_valid` is never 1 in the same cycle as `ref_ready`.
- R10: While `pf_valid` is 1 and `pf_ready` is 0, `pf_valid` stays 1 and `pf_line` stays unchanged on the next cycle. No request is lost.
- R11: Target addresses wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Reference access offered |
| ref_ready | output | 1 | Issuer idle, reference may be accepted |
| ref_line | input | 32 | Reference cache-line address |
| off_tbl | input | 96 | 16 signed 6-bit offsets |
| score_tbl | input | 160 | 16 unsigned 10-bit scores |
| degree | input | 4 | Per-direction prefetch degree |
| pf_valid | output | 1 | Prefetch request valid |
| pf_ready | input | 1 | Prefetch request accepted |
| pf_line | output | 32 | Prefetch cache-line address |

## Verification
The hardest case to reach from the ports is a set of duplicate targets that land close to the end of the budget. To produce it, two offsets must be multiples of each other, both must have high scores, and the degree must be small enough for the skip to change which lines are issued. The random stimulus therefore draws offsets from a narrow band of small magnitudes and draws scores biased toward the upper thresholds. This makes collisions between strides frequent. It also toggles `pf_ready` at random, so that stalls occur in the same cycles as skips. Directed cases add clamping of the degree, a change of the degree in the middle of a sequence, and address wrap-around.

// File: rtl/pf_issue_pkg.sv
package pf_issue_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_EMIT} pf_state_e;

  function automatic logic [5:0] abs6(input logic [5:0] v);
    return v[5] ? (~v + 6'd1) : v;
  endfunction
endpackage

// File: rtl/pf_grade.sv
module pf_grade #(
  parameter int N_OFF   = 16,
  parameter int OFF_W   = 6,
  parameter int SCORE_W = 10,
  parameter int THR1    = 256,
  parameter int THR2    = 512,
  parameter int THR3    = 768
) (
  input  logic [N_OFF*OFF_W-1:0]   offs,
  input  logic [N_OFF*SCORE_W-1:0] scores,
  output logic [N_OFF*2-1:0]       allow,
  output logic [N_OFF-1:0]         qual
);
  for (genvar i = 0; i < N_OFF; i++) begin : g_ent
    logic [SCORE_W-1:0] s;
    logic               nz;
    assign s  = scores[i*SCORE_W +: SCORE_W];
    assign nz = |offs[i*OFF_W +: OFF_W];
    always_comb begin
      if (!nz)                              allow[i*2 +: 2] = 2'd0;
      else if (s >= SCORE_W'(THR3))         allow[i*2 +: 2] = 2'd3;
      else if (s >= SCORE_W'(THR2))         allow[i*2 +: 2] = 2'd2;
      else if (s >= SCORE_W'(THR1))         allow[i*2 +: 2] = 2'd1;
      else                                  allow[i*2 +: 2] = 2'd0;
    end
    assign qual[i] = |allow[i*2 +: 2];
  end
endmodule

// File: rtl/pf_pick.sv
module pf_pick #(
  parameter int N_OFF = 16,
  parameter int OFF_W = 6,
  localparam int IDX_W = $clog2(N_OFF)
) (
  input  logic [N_OFF-1:0]       cand,
  input  logic [N_OFF*OFF_W-1:0] offs,
  output logic                   found,
  output logic [IDX_W-1:0]       idx,
  output logic [OFF_W-1:0]       mag
);
  always_comb begin
    logic [OFF_W-1:0] o, m;
    found = 1'b0;
    idx   = '0;
    mag   = '1;
    for (int i = 0; i < N_OFF; i++) begin
      o = offs[i*OFF_W +: OFF_W];
      m = o[OFF_W-1] ? (~o + 1'b1) : o;
      // strict compare keeps the lowest index on equal magnitude
      if (cand[i] && (!found || m < mag)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        mag   = m;
      end
    end
  end
endmodule

// File: rtl/pf_hist.sv
module pf_hist #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              wr,
  input  logic [ADDR_W-1:0] probe,
  output logic              hit
);
  logic [ADDR_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (CNT_W'(i) < cnt && mem[i] == probe) hit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else if (wr && cnt < CNT_W'(DEPTH)) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && !clear && cnt == CNT_W'(i)) mem[i] <= probe;
    end
  end

  // R8
  no_dup_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> !hit);
  // R6
  hist_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> cnt < CNT_W'(DEPTH));
endmodule

// File: rtl/pf_issue.sv
module pf_issue
  import pf_issue_pkg::*;
#(
  parameter int N_OFF   = 16,
  parameter int OFF_W   = 6,
  parameter int SCORE_W = 10,
  parameter int ADDR_W  = 32,
  parameter int DEG_W   = 4,
  parameter int DEG_MAX = 8,
  parameter int THR1    = 256,
  parameter int THR2    = 512,
  parameter int THR3    = 768
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ref_valid,
  output logic                     ref_ready,
  input  logic [ADDR_W-1:0]        ref_line,
  input  logic [N_OFF*OFF_W-1:0]   off_tbl,
  input  logic [N_OFF*SCORE_W-1:0] score_tbl,
  input  logic [DEG_W-1:0]         degree,
  output logic                     pf_valid,
  input  logic                     pf_ready,
  output logic [ADDR_W-1:0]        pf_line
);
  localparam int IDX_W  = $clog2(N_OFF);
  localparam int CNT_W  = $clog2(DEG_MAX + 1);
  localparam int PROD_W = OFF_W + 3;
  localparam int HIST_D = 2 * DEG_MAX;

  pf_state_e               st;
  logic [ADDR_W-1:0]       ref_q;
  logic [N_OFF*OFF_W-1:0]  offs_q;
  logic [N_OFF*2-1:0]      allow_q, allow_in;
  logic [N_OFF-1:0]        qual_in, pend_q, neg_mask, cand;
  logic [CNT_W-1:0]        deg_c, deg_q, budget;
  logic                    neg_q;
  logic [IDX_W-1:0]        cur_idx, pick_idx;
  logic [1:0]              step, cur_allow;
  logic                    pick_found, hit, last, hs, clr;
  logic [OFF_W-1:0]        pick_mag, cur_off, prev_mag;
  logic                    have_prev;
  logic signed [PROD_W-1:0] prod;

  pf_grade #(.N_OFF(N_OFF), .OFF_W(OFF_W), .SCORE_W(SCORE_W),
             .THR1(THR1), .THR2(THR2), .THR3(THR3)) i_grade (
    .offs(off_tbl), .scores(score_tbl), .allow(allow_in), .qual(qual_in));

  for (genvar i = 0; i < N_OFF; i++) begin : g_sign
    assign neg_mask[i] = offs_q[i*OFF_W + OFF_W - 1];
  end
  assign cand = pend_q & (neg_q ? neg_mask : ~neg_mask);

  pf_pick #(.N_OFF(N_OFF), .OFF_W(OFF_W)) i_pick (
    .cand(cand), .offs(offs_q), .found(pick_found), .idx(pick_idx),
    .mag(pick_mag));

  always_comb begin
    if (degree == '0)                        deg_c = CNT_W'(1);
    else if (degree > DEG_W'(DEG_MAX))       deg_c = CNT_W'(DEG_MAX);
    else                                     deg_c = CNT_W'(degree);
  end

  assign cur_off   = offs_q[cur_idx*OFF_W +: OFF_W];
  assign cur_allow = allow_q[cur_idx*2 +: 2];
  assign prod      = PROD_W'($signed(cur_off)) * PROD_W'($signed({1'b0, step}));
  assign pf_line   = ref_q + {{(ADDR_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign last      = (step == cur_allow);
  assign ref_ready = (st == ST_IDLE);
  assign pf_valid  = (st == ST_EMIT) && !hit;
  assign hs        = pf_valid && pf_ready;
  assign clr       = ref_ready && ref_valid;

  pf_hist #(.ADDR_W(ADDR_W), .DEPTH(HIST_D)) i_hist (
    .clk(clk), .rst_n(rst_n), .clear(clr), .wr(hs), .probe(pf_line),
    .hit(hit));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ref_q     <= '0;
      offs_q    <= '0;
      allow_q   <= '0;
      pend_q    <= '0;
      deg_q     <= '0;
      budget    <= '0;
      neg_q     <= 1'b0;
      cur_idx   <= '0;
      step      <= '0;
      prev_mag  <= '0;
      have_prev <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (ref_valid) begin
          ref_q     <= ref_line;
          offs_q    <= off_tbl;
          allow_q   <= allow_in;
          pend_q    <= qual_in;
          deg_q     <= deg_c;
          budget    <= deg_c;
          neg_q     <= 1'b0;
          have_prev <= 1'b0;
          st        <= ST_PICK;
        end
        ST_PICK: begin
          if (pick_found && budget != '0) begin
            cur_idx          <= pick_idx;
            step             <= 2'd1;
            pend_q[pick_idx] <= 1'b0;
            prev_mag         <= pick_mag;
            have_prev        <= 1'b1;
            st               <= ST_EMIT;
          end else if (!neg_q) begin
            neg_q     <= 1'b1;
            budget    <= deg_q;
            have_prev <= 1'b0;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_EMIT: begin
          if (hit) begin
            if (last) st <= ST_PICK;
            else      step <= step + 2'd1;
          end else if (pf_ready) begin
            budget <= budget - 1'b1;
            if (last || budget == CNT_W'(1)) st <= ST_PICK;
            else                             step <= step + 2'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid && !pf_ready |=> pf_valid && $stable(pf_line));
  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ready |-> !pf_valid);
  // R6
  budget_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> budget != '0);
  // R5
  mag_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PICK) && pick_found && budget != '0 && have_prev |-> pick_mag >= prev_mag);
endmodule

// File: tb/test_pf_issue.sv
module test_pf_issue;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_valid = 1'b0;
  logic        ref_ready;
  logic [31:0] ref_line = '0;
  logic [95:0] off_tbl = '0;
  logic [159:0] score_tbl = '0;
  logic [3:0]  degree = 4'd1;
  logic        pf_valid;
  logic        pf_ready = 1'b0;
  logic [31:0] pf_line;

  int total = 0;
  int bad = 0;
  int offs_t [N];
  int scores_t [N];
  logic [31:0] exp_q [$];
  logic [31:0] got_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_issue i_pf_issue (
    .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_ready(ref_ready),
    .ref_line(ref_line), .off_tbl(off_tbl), .score_tbl(score_tbl),
    .degree(degree), .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_line(pf_line));

  function automatic int lines_for(int s);
    if (s >= 768) return 3;
    if (s >= 512) return 2;
    if (s >= 256) return 1;
    return 0;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic build_expected(input logic [31:0] a, input int deg);
    int d;
    d = (deg < 1) ? 1 : (deg > 8 ? 8 : deg);
    exp_q.delete();
    for (int dir = 0; dir < 2; dir++) begin
      int budget = d;
      for (int m = 1; m < 32; m++) begin
        for (int i = 0; i < N; i++) begin
          int o = offs_t[i];
          if ((dir == 0 && o == m) || (dir == 1 && o == -m)) begin
            for (int k = 1; k <= lines_for(scores_t[i]); k++) begin
              logic [31:0] t;
              bit dup = 0;
              if (budget == 0) break;
              t = a + 32'(o * k);
              foreach (exp_q[j]) if (exp_q[j] == t) dup = 1;
              if (!dup) begin
                exp_q.push_back(t);
                budget--;
              end
            end
          end
        end
      end
    end
  endtask

  task automatic run_access(input logic [31:0] a, input int deg, input int deg_late,
                            input int ready_pct, input string tag);
    bit stalled = 0;
    logic [31:0] held = '0;
    bit overlap = 0;
    build_expected(a, deg);
    got_q.delete();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      off_tbl[i*6 +: 6]    = offs_t[i][5:0];
      score_tbl[i*10 +: 10] = scores_t[i][9:0];
    end
    ref_line  = a;
    degree    = 4'(deg);
    ref_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_valid = 1'b0;
    if (deg_late >= 0) begin
      degree = 4'(deg_late);
      for (int i = 0; i < N; i++) score_tbl[i*10 +: 10] = 10'd0;
    end
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (stalled) begin
        // R10: held request must persist unchanged
        check(pf_valid && pf_line == held, "R10", pf_line, held);
      end
      pf_ready = ($urandom_range(0, 99) < ready_pct);
      #1;
      if (pf_valid && ref_ready) overlap = 1;
      if (ref_ready && !pf_valid) break;
      stalled = pf_valid && !pf_ready;
      held    = pf_line;
      if (pf_valid && pf_ready) got_q.push_back(pf_line);
      @(negedge clk);
    end
    pf_ready = 1'b0;
    check(!overlap, "R9", 32'(overlap), 32'd0);
    check(got_q.size() == exp_q.size(), {tag, " count"}, 32'(got_q.size()),
          32'(exp_q.size()));
    for (int j = 0; j < exp_q.size() && j < got_q.size(); j++)
      check(got_q[j] == exp_q[j], tag, got_q[j], exp_q[j]);
  endtask

  task automatic clear_tbl();
    for (int i = 0; i < N; i++) begin
      offs_t[i] = 0;
      scores_t[i] = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    check(ref_ready == 1'b1, "R1 ready", 32'(ref_ready), 32'd1);
    check(pf_valid == 1'b0, "R1 valid", 32'(pf_valid), 32'd0);
    rst_n = 1'b1;

    // R2: sub-threshold scores and zero offset
    clear_tbl();
    offs_t[0] = 2;  scores_t[0] = 255;
    offs_t[1] = 0;  scores_t[1] = 1023;
    offs_t[2] = -1; scores_t[2] = 100;
    offs_t[3] = 5;  scores_t[3] = 256;
    run_access(32'h1000, 8, -1, 100, "R2");

    // R3: one, two and three lines
    clear_tbl();
    offs_t[0] = 3;  scores_t[0] = 767;
    offs_t[1] = 7;  scores_t[1] = 768;
    offs_t[2] = -4; scores_t[2] = 511;
    offs_t[3] = -9; scores_t[3] = 512;
    run_access(32'h2000, 8, -1, 100, "R3");

    // R4/R5: direction and magnitude order with a tie on index
    clear_tbl();
    offs_t[0] = -1; scores_t[0] = 300;
    offs_t[1] = 6;  scores_t[1] = 300;
    offs_t[2] = 2;  scores_t[2] = 300;
    offs_t[3] = -5; scores_t[3] = 300;
    offs_t[4] = 4;  scores_t[4] = 600;
    offs_t[5] = 4;  scores_t[5] = 300;
    run_access(32'h3000, 8, -1, 60, "R4 R5");

    // R6: degree 0 acts as 1, degree 15 acts as 8
    clear_tbl();
    for (int i = 0; i < 8; i++) begin
      offs_t[i] = i + 1;    scores_t[i] = 1000;
      offs_t[i+8] = -(i + 9); scores_t[i+8] = 1000;
    end
    run_access(32'h4000, 0, -1, 100, "R6 low");
    run_access(32'h4000, 15, -1, 70, "R6 high");

    // R7: late degree and table change are ignored
    run_access(32'h5000, 3, 8, 50, "R7");

    // R8: strides 1 and 2 collide
    clear_tbl();
    offs_t[0] = 2; scores_t[0] = 800;
    offs_t[1] = 1; scores_t[1] = 800;
    offs_t[2] = 4; scores_t[2] = 800;
    run_access(32'h6000, 5, -1, 100, "R8");

    // R11: wrap at both ends
    clear_tbl();
    offs_t[0] = 3;  scores_t[0] = 900;
    offs_t[1] = -2; scores_t[1] = 900;
    run_access(32'hFFFF_FFFE, 8, -1, 100, "R11 top");
    run_access(32'h0000_0001, 8, -1, 100, "R11 bottom");

    // random mix with narrow strides to provoke duplicates and stalls
    for (int r = 0; r < 80; r++) begin
      for (int i = 0; i < N; i++) begin
        offs_t[i]   = (r % 3 == 0) ? $urandom_range(0, 32) - 16 : $urandom_range(0, 8) - 4;
        scores_t[i] = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255)
                                                  : $urandom_range(256, 1023);
      end
      run_access($urandom(), $urandom_range(0, 15), -1, $urandom_range(30, 100),
                 "R3 R4 R5 R6 R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule